// File: doc/BRIEF.md
# Tagged Receive Character Queue

This block sits between a serial receiver and a register-style read port. Each character the receiver finishes arrives on a push strobe as an 8-bit byte with three error flags: break, parity and framing. The block stores it as a 12-bit tagged word in a 16-entry queue. A read strobe takes the oldest word off the queue and holds it on the read port until the next successful read. A four-bit sticky error status shows the flags of the character read last. It also records queue overruns, and a write strobe on the clear input empties it.

When the queue is turned off, it works as a single holding register. A character that arrives while the store is full is lost. What was already stored stays valid, the overrun flag rises on the next cycle, and the next character that is stored carries an overrun tag, so the reader meets the loss in stream order. Three request outputs come from the fill level. A threshold interrupt and a burst DMA request follow a programmable fraction of the depth. A single DMA request is raised whenever anything is stored.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: With `fifo_en` high, up to 16 words are held and read back in arrival order. `rd_word` bit 11 is the overrun tag, bit 10 break, bit 9 parity, bit 8 framing, and bits 7:0 the data byte.
- R2: With `fifo_en` low, exactly one character is held. A second character pushed before it is read is an overrun.
- R3: A push while the store is full (judged by the level before that cycle) writes nothing and leaves the stored words intact. The next word that is stored has bit 11 set, and later words do not.
- R4: `err_status[3]` (overrun) is high on the cycle after an overrun push.
- R5: After a read, `err_status[2:0]` equals bits 10:8 of the word just read. Reading a word with bit 11 set also sets `err_status[3]`.
- R6: A cycle with `err_clr` high clears all four status bits, and reset clears them too. An overrun or a read in the same cycle still sets its bits.
- R7: `irq_thresh` is high exactly while the level is at or above the threshold. The threshold is max(1, depth*k/8), with k = 1, 2, 4, 6, 7 for `trig_sel` = 0..4 and k = 4 for the other codes. The depth is 16, or 1 when the queue is off.
- R8: `dma_single` is high whenever the level is non-zero. `dma_burst` is high while the level is at or above the R7 threshold.
- R9: A read strobe while the store is empty leaves `rd_word`, `err_status` and the level unchanged.
- R10: After reset the store is empty, `rd_word` is 0, `err_status` is 0 and all request outputs are low.
- R11: A push and a read in the same cycle on a store that is not full both take effect, and the level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: 16-entry queue, 0: single holding register (change only while empty) |
| trig_sel | input | 3 | Threshold fraction select |
| push_valid | input | 1 | A received character is offered |
| push_data | input | 8 | Received byte |
| push_err | input | 3 | Receiver flags: [2] break, [1] parity, [0] framing |
| pop | input | 1 | Read strobe for the data port |
| rd_word | output | 12 | Last word read, tag in 11:8 |
| err_clr | input | 1 | Error-clear write strobe |
| err_status | output | 4 | [3] overrun, [2] break, [1] parity, [0] framing |
| irq_thresh | output | 1 | Level at or above threshold |
| dma_single | output | 1 | Queue not empty |
| dma_burst | output | 1 | Burst DMA request at threshold |

## Verification
Some properties are checked on every cycle. The level never exceeds the depth. An overrun leaves the level as it was. The overrun flag follows an overrun on the next cycle. The status bits follow the tag of the word just read, and a clear with no competing event leaves zero. A read from an empty store holds `rd_word`. A same-cycle push and read keep the level, and a burst request never appears without a single request.

Other behaviour only shows up over a whole sequence, so the scenarios cover it. These include arrival order, where the overrun tag lands after a loss, the holding-register mode, the threshold edges for several `trig_sel` codes, and the clear-versus-overrun priority.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FLAG_W  = 3;
  localparam int unsigned TAG_W   = FLAG_W + 1;
  localparam int unsigned WORD_W  = DATA_W + TAG_W;
  localparam int unsigned OVR_BIT = WORD_W - 1;

  // Threshold level for a given active depth and fraction code (eighths).
  function automatic int unsigned trig_level(int unsigned depth, logic [2:0] sel);
    int unsigned eighths;
    int unsigned lvl;
    case (sel)
      3'd0:    eighths = 1;
      3'd1:    eighths = 2;
      3'd2:    eighths = 4;
      3'd3:    eighths = 6;
      3'd4:    eighths = 7;
      default: eighths = 4;
    endcase
    lvl = (depth * eighths) / 8;
    if (lvl == 0) lvl = 1;
    return lvl;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fifo_en,
  input  logic                         push_valid,
  input  logic [DATA_W-1:0]            push_data,
  input  logic [FLAG_W-1:0]            push_err,
  input  logic                         pop,
  output logic [WORD_W-1:0]            rd_word,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         overrun_evt,
  output logic                         pop_fire,
  output logic [WORD_W-1:0]            popped
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     depth_now;
  logic              full, push_fire, ovr_pend;

  assign depth_now   = fifo_en ? CW'(DEPTH) : CW'(1);
  assign full        = (count >= depth_now);
  assign push_fire   = push_valid && !full;
  assign overrun_evt = push_valid && full;
  assign pop_fire    = pop && (count != '0);
  assign popped      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= {ovr_pend, push_err, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      ovr_pend <= 1'b0;
      rd_word  <= '0;
    end else begin
      if (push_fire) wr_ptr <= fifo_en ? wr_ptr + 1'b1 : '0;
      if (pop_fire) begin
        rd_ptr  <= fifo_en ? rd_ptr + 1'b1 : '0;
        rd_word <= popped;
      end
      count <= count + CW'(push_fire) - CW'(pop_fire);
      if (push_fire)        ovr_pend <= 1'b0;
      else if (overrun_evt) ovr_pend <= 1'b1;
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R3
  overrun_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt && !pop_fire |=> $stable(count));
  // R9
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && (count == '0) |=> $stable(rd_word));
  // R11
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !full && pop && (count != '0) |=> $stable(count));
endmodule

// File: rtl/rxq_errstat.sv
module rxq_errstat
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_clr,
  input  logic             overrun_evt,
  input  logic             pop_fire,
  input  logic [TAG_W-1:0] popped_tag,
  output logic [TAG_W-1:0] status
);
  logic [TAG_W-1:0] status_nxt;

  always_comb begin
    status_nxt = err_clr ? '0 : status;
    if (pop_fire) begin
      status_nxt[FLAG_W-1:0] = popped_tag[FLAG_W-1:0];
      status_nxt[TAG_W-1]    = status_nxt[TAG_W-1] | popped_tag[TAG_W-1];
    end
    if (overrun_evt) status_nxt[TAG_W-1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_nxt;
  end

  // R4
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> status[TAG_W-1]);
  // R5
  tag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> status[FLAG_W-1:0] == $past(popped_tag[FLAG_W-1:0]));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !overrun_evt && !pop_fire |=> status == '0);
endmodule

// File: rtl/rxq_req.sv
module rxq_req
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                       fifo_en,
  input  logic [2:0]                 trig_sel,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       irq_thresh,
  output logic                       dma_single,
  output logic                       dma_burst
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  logic [CW-1:0] thr;

  assign thr        = CW'(trig_level(fifo_en ? DEPTH : 1, trig_sel));
  assign irq_thresh = (count >= thr);
  assign dma_burst  = (count >= thr);
  assign dma_single = (count != '0);

  // R8
  always_comb begin
    burst_implies_single_chk: assert (!dma_burst || dma_single);
  end
endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [2:0]        trig_sel,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic [FLAG_W-1:0] push_err,
  input  logic              pop,
  output logic [WORD_W-1:0] rd_word,
  input  logic              err_clr,
  output logic [TAG_W-1:0]  err_status,
  output logic              irq_thresh,
  output logic              dma_single,
  output logic              dma_burst
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0]     level;
  logic              overrun_evt, pop_fire;
  logic [WORD_W-1:0] popped;

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .push_valid(push_valid), .push_data(push_data), .push_err(push_err),
    .pop(pop), .rd_word(rd_word), .count(level),
    .overrun_evt(overrun_evt), .pop_fire(pop_fire), .popped(popped)
  );

  rxq_errstat u_err (
    .clk(clk), .rst_n(rst_n), .err_clr(err_clr),
    .overrun_evt(overrun_evt), .pop_fire(pop_fire),
    .popped_tag(popped[WORD_W-1:DATA_W]), .status(err_status)
  );

  rxq_req #(.DEPTH(DEPTH)) u_req (
    .fifo_en(fifo_en), .trig_sel(trig_sel), .count(level),
    .irq_thresh(irq_thresh), .dma_single(dma_single), .dma_burst(dma_burst)
  );

  // R2
  single_mode_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en && $stable(fifo_en) |-> level <= CW'(1));
endmodule

// File: tb/tb_rxq_tagged_fifo.sv
`timescale 1ns/1ps
module tb_rxq_tagged_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b1;
  logic [2:0] trig_sel = 3'd1;
  logic push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic [2:0] push_err = '0;
  logic pop = 1'b0;
  logic err_clr = 1'b0;
  logic [11:0] rd_word;
  logic [3:0] err_status;
  logic irq_thresh, dma_single, dma_burst;

  always #2 clk = ~clk;

  rxq_tagged_fifo dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .push_valid(push_valid), .push_data(push_data), .push_err(push_err),
    .pop(pop), .rd_word(rd_word), .err_clr(err_clr), .err_status(err_status),
    .irq_thresh(irq_thresh), .dma_single(dma_single), .dma_burst(dma_burst)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [11:0] sbq[$];
  bit m_pend = 1'b0;
  bit m_ovr = 1'b0;
  logic [2:0] m_tags = '0;
  logic [11:0] m_last = '0;
  int m_depth = 16;

  task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string req);
    check(act === exp, req, {11'd0, act}, {11'd0, exp});
  endtask

  // Driver: offers one character, records the expected stored word or an overrun.
  task automatic drive_push(input logic [7:0] d, input logic [2:0] e);
    @(negedge clk);
    push_valid = 1'b1; push_data = d; push_err = e;
    if (sbq.size() < m_depth) begin
      sbq.push_back({m_pend, e, d});
      m_pend = 1'b0;
    end else begin
      m_pend = 1'b1;
      m_ovr  = 1'b1;
    end
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  // Monitor: reads one word and compares it with the scoreboard head.
  task automatic read_cmp(input string req);
    logic [11:0] exp;
    @(negedge clk);
    pop = 1'b1;
    if (sbq.size() > 0) begin
      exp = sbq.pop_front();
      m_last = exp;
      m_tags = exp[10:8];
      m_ovr  = m_ovr | exp[11];
    end else exp = m_last;
    @(negedge clk);
    pop = 1'b0;
    check(rd_word === exp, req, rd_word, exp);
    check(err_status === {m_ovr, m_tags}, "R5 status", {8'd0, err_status}, {8'd0, m_ovr, m_tags});
  endtask

  task automatic clear_err();
    @(negedge clk);
    err_clr = 1'b1;
    m_ovr = 1'b0; m_tags = '0;
    @(negedge clk);
    err_clr = 1'b0;
    check(err_status === 4'd0, "R6 clear", {8'd0, err_status}, 12'd0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(rd_word === 12'd0, "R10 rd_word", rd_word, 12'd0);
    check(err_status === 4'd0, "R10 status", {8'd0, err_status}, 12'd0);
    check_bit(irq_thresh | dma_single | dma_burst, 1'b0, "R10 requests");
    rst_n = 1'b1;

    // R7/R8 thresholds with trig_sel=1 -> 4 of 16
    drive_push(8'h11, 3'b000);
    drive_push(8'h22, 3'b100);
    drive_push(8'h33, 3'b010);
    check_bit(dma_single, 1'b1, "R8 single");
    check_bit(irq_thresh, 1'b0, "R7 below");
    check_bit(dma_burst, 1'b0, "R8 burst below");
    drive_push(8'h44, 3'b001);
    check_bit(irq_thresh, 1'b1, "R7 at level");
    check_bit(dma_burst, 1'b1, "R8 burst at level");
    read_cmp("R1 order");
    check_bit(irq_thresh, 1'b0, "R7 drop");
    read_cmp("R1 order");
    read_cmp("R1 order");
    read_cmp("R1 order");
    check_bit(dma_single, 1'b0, "R8 empty");

    // R3/R4 overrun in queue mode
    for (int i = 0; i < 16; i++) drive_push(8'(8'h80 + i), 3'(i % 8));
    drive_push(8'hEE, 3'b111);
    check_bit(err_status[3], 1'b1, "R4 overrun flag");
    drive_push(8'hEF, 3'b000);
    for (int i = 0; i < 16; i++) read_cmp("R3 contents intact");
    clear_err();
    drive_push(8'h5A, 3'b000);
    drive_push(8'h5B, 3'b000);
    read_cmp("R3 tag on next word");
    read_cmp("R3 tag only once");
    clear_err();

    // R9 empty read
    read_cmp("R9 empty read");
    check_bit(dma_single, 1'b0, "R9 level unchanged");

    // R11 simultaneous push and read
    drive_push(8'hA1, 3'b000);
    drive_push(8'hA2, 3'b010);
    @(negedge clk);
    push_valid = 1'b1; push_data = 8'hA3; push_err = 3'b001; pop = 1'b1;
    sbq.push_back({1'b0, 3'b001, 8'hA3});
    m_last = sbq.pop_front(); m_tags = m_last[10:8];
    @(negedge clk);
    push_valid = 1'b0; pop = 1'b0;
    check(rd_word === m_last, "R11 read", rd_word, m_last);
    read_cmp("R11 order");
    read_cmp("R11 order");
    check_bit(dma_single, 1'b0, "R11 level");

    // R2 holding-register mode
    fifo_en = 1'b0; m_depth = 1;
    drive_push(8'hC1, 3'b000);
    check_bit(irq_thresh, 1'b1, "R7 depth one");
    drive_push(8'hC2, 3'b000);
    check_bit(err_status[3], 1'b1, "R2 overrun single");
    read_cmp("R2 holds first");
    drive_push(8'hC3, 3'b000);
    read_cmp("R2 tag after loss");

    // R6 priority: clear and overrun in one cycle
    clear_err();
    drive_push(8'hD1, 3'b000);
    @(negedge clk);
    err_clr = 1'b1; push_valid = 1'b1; push_data = 8'hD2;
    m_pend = 1'b1; m_ovr = 1'b1; m_tags = '0;
    @(negedge clk);
    err_clr = 1'b0; push_valid = 1'b0;
    check(err_status === 4'b1000, "R6 overrun wins", {8'd0, err_status}, 12'h008);
    read_cmp("R2 drain");
    clear_err();
    drive_push(8'hD3, 3'b000);
    read_cmp("R3 tag single mode");

    // R7 with trig_sel=4 -> 14 of 16
    fifo_en = 1'b1; m_depth = 16; trig_sel = 3'd4;
    for (int i = 0; i < 13; i++) drive_push(8'(i), 3'b000);
    check_bit(irq_thresh, 1'b0, "R7 13 of 14");
    drive_push(8'h0D, 3'b000);
    check_bit(irq_thresh, 1'b1, "R7 14 of 14");
    trig_sel = 3'd7;
    #1 check_bit(irq_thresh, 1'b1, "R7 default half");
    for (int i = 0; i < 14; i++) read_cmp("R1 drain");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule